// File: doc/BRIEF.md
# Windowed Error-Rate Threshold Alarm

This block estimates whether a line is running at an error rate of one in a million or worse. Every single-cycle coding-violation pulse from the line decoder is counted over a fixed sampling window. The window is timed by a slow reference clock, nominally 8 kHz, that is unrelated to the line clock. The reference clock enters as a plain data input. It passes through a two-flop synchroniser and its rising edges are counted in the line-clock domain. A default window is 80000 reference edges, which is ten seconds.

When a window closes, the block compares the number of violations seen in it against a threshold. At 44.736 Mbit/s over ten seconds, the default threshold is 447. The result is loaded into an active-low alarm, and that alarm stays unchanged for all of the following window. The violation count then starts again from zero. If the reference clock stops, the alarm has no meaning. A watchdog therefore counts line cycles without a reference edge and, once that count reaches a limit, forces the alarm inactive and restarts the window.

Top module: `ber_window_alarm`

## Requirements
- R1: While reset is held, and after it is released, the alarm output is high (inactive) and the violation and edge counts start from zero.
- R2: A rising edge on the reference input takes effect through a two-flop synchroniser. When that edge closes a window, the alarm changes on the third rising line-clock edge, counting the edge that first samples the reference high as the first.
- R3: A window closes on its WINDOW_EDGES-th counted reference rising edge. If the window collected ERR_THRESH or more violation pulses, the alarm goes low.
- R4: If a window collects ERR_THRESH-1 or fewer violation pulses, the alarm goes high (inactive) when that window closes.
- R5: Between two window closures, and while the reference clock is alive, the alarm does not change, whatever violations arrive.
- R6: The violation count saturates and never wraps. Any number of pulses at or above ERR_THRESH in one window still yields a low alarm.
- R7: The count is cleared at each window closure after the comparison. A pulse on the closing cycle counts towards the new window.
- R8: If no reference rising edge arrives for TIMEOUT line cycles, the alarm is forced high and the count and edge tally are cleared. The edge that ends the stall is not counted, and the next window closes after WINDOW_EDGES further edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cv_pulse_i | input | 1 | One-cycle coding-violation pulse, line-clock domain |
| ref_clk_i | input | 1 | Slow reference clock, sampled as asynchronous data |
| alarm_no | output | 1 | Error-rate alarm, low = rate at or above threshold |

## Verification
The only result is the alarm. It can move solely in the cycle after the synchronised edge that closes a window, or after the watchdog expires. That is two register stages past the sampling flop for a reference edge, and one register past the counter state for a violation pulse. The bench drives both inputs on the falling clock edge. It updates its own requirement-level model once per rising edge and compares the alarm on every falling edge. Each comparison therefore lands exactly one model step after the inputs that caused it. Directed windows place exactly ERR_THRESH-1, exactly ERR_THRESH and a flood of pulses, and they stop the reference clock long enough to trip the watchdog.

// File: rtl/ber_pkg.sv
package ber_pkg;
    localparam int unsigned DEF_WINDOW_EDGES = 80000;
    localparam int unsigned DEF_ERR_THRESH   = 447;
    localparam int unsigned DEF_TIMEOUT      = 20000;
    localparam int unsigned SYNC_STAGES      = 2;
endpackage

// File: rtl/ber_ref_sync.sv
module ber_ref_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    output logic rise_o
);
    import ber_pkg::*;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[SYNC_STAGES-2:0], ref_i};
        st_d.last  = st_q.chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = st_q.chain[SYNC_STAGES-1] & ~st_q.last;
endmodule

// File: rtl/ber_window_timer.sv
module ber_window_timer #(
    parameter int unsigned WINDOW_EDGES = ber_pkg::DEF_WINDOW_EDGES,
    parameter int unsigned TIMEOUT      = ber_pkg::DEF_TIMEOUT
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    output logic win_end_o,
    output logic stale_o
);
    localparam int unsigned EDGE_W = (WINDOW_EDGES > 1) ? $clog2(WINDOW_EDGES) : 1;
    localparam int unsigned IDLE_W = $clog2(TIMEOUT + 1);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(WINDOW_EDGES - 1);
    localparam logic [IDLE_W-1:0] IDLE_MAX  = IDLE_W'(TIMEOUT);

    typedef struct packed {
        logic [EDGE_W-1:0] edges;
        logic [IDLE_W-1:0] idle;
    } tmr_t;

    tmr_t st_d, st_q;
    logic stale;
    logic close;

    assign stale = (st_q.idle == IDLE_MAX);
    assign close = rise_i & ~stale & (st_q.edges == LAST_EDGE);

    always_comb begin
        st_d = st_q;
        if (rise_i)             st_d.idle = '0;
        else if (!stale)        st_d.idle = st_q.idle + 1'b1;

        if (stale)              st_d.edges = '0;
        else if (close)         st_d.edges = '0;
        else if (rise_i)        st_d.edges = st_q.edges + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign win_end_o = close;
    assign stale_o   = stale;
endmodule

// File: rtl/ber_err_counter.sv
module ber_err_counter #(
    parameter int unsigned ERR_THRESH = ber_pkg::DEF_ERR_THRESH,
    parameter int unsigned CNT_W      = $clog2(ERR_THRESH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cv_i,
    input  logic             win_end_i,
    input  logic             stale_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(ERR_THRESH);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stale_i)                  st_d.cnt = '0;
        else if (win_end_i)           st_d.cnt = {{(CNT_W-1){1'b0}}, cv_i};
        else if (cv_i && st_q.cnt != CAP) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/ber_window_alarm.sv
module ber_window_alarm #(
    parameter int unsigned WINDOW_EDGES = ber_pkg::DEF_WINDOW_EDGES,
    parameter int unsigned ERR_THRESH   = ber_pkg::DEF_ERR_THRESH,
    parameter int unsigned TIMEOUT      = ber_pkg::DEF_TIMEOUT
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cv_pulse_i,
    input  logic ref_clk_i,
    output logic alarm_no
);
    localparam int unsigned CNT_W = $clog2(ERR_THRESH + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ERR_THRESH);

    typedef struct packed {
        logic alarm_n;
    } top_t;

    logic             ref_rise;
    logic             win_end;
    logic             stale;
    logic [CNT_W-1:0] err_cnt;
    top_t             st_d, st_q;

    ber_ref_sync u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ref_i  (ref_clk_i),
        .rise_o (ref_rise)
    );

    ber_window_timer #(
        .WINDOW_EDGES (WINDOW_EDGES),
        .TIMEOUT      (TIMEOUT)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (ref_rise),
        .win_end_o (win_end),
        .stale_o   (stale)
    );

    ber_err_counter #(
        .ERR_THRESH (ERR_THRESH),
        .CNT_W      (CNT_W)
    ) u_count (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cv_i      (cv_pulse_i),
        .win_end_i (win_end),
        .stale_i   (stale),
        .count_o   (err_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (stale)        st_d.alarm_n = 1'b1;
        else if (win_end) st_d.alarm_n = (err_cnt < LIMIT);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{alarm_n: 1'b1};
        else         st_q <= st_d;
    end

    assign alarm_no = st_q.alarm_n;
endmodule

// File: rtl/ber_window_alarm_chk.sv
module ber_window_alarm_chk #(
    parameter int unsigned ERR_THRESH = ber_pkg::DEF_ERR_THRESH,
    parameter int unsigned CNT_W      = $clog2(ERR_THRESH + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             alarm_no,
    input logic             win_end,
    input logic             stale,
    input logic             ref_rise,
    input logic [CNT_W-1:0] err_cnt
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(ERR_THRESH);

    AST_HOLD_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!win_end && !stale) |=> $stable(alarm_no)); // R5

    AST_STALE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stale |=> alarm_no); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_cnt <= CAP); // R6

    AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_cnt == CAP && !win_end && !stale) |=> err_cnt == CAP); // R6

    AST_WINDOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_end |=> err_cnt <= 1); // R7

    AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_rise |=> !ref_rise); // R2

    AST_CLOSE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_end && !stale && err_cnt == CAP) |=> !alarm_no); // R3
endmodule

bind ber_window_alarm ber_window_alarm_chk #(
    .ERR_THRESH (ERR_THRESH)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alarm_no (alarm_no),
    .win_end  (win_end),
    .stale    (stale),
    .ref_rise (ref_rise),
    .err_cnt  (err_cnt)
);

// File: tb/ber_window_alarm_test.sv
module ber_window_alarm_test;
    localparam int unsigned WE   = 4;
    localparam int unsigned TH   = 5;
    localparam int unsigned TO   = 60;
    localparam int unsigned HALF = 5;

    logic clk_i = 1'b0;
    logic rst_ni, cv_pulse_i, ref_clk_i;
    logic alarm_no;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    ber_window_alarm #(.WINDOW_EDGES(WE), .ERR_THRESH(TH), .TIMEOUT(TO)) uut (
        .clk_i(clk_i), .rst_ni(rst_ni), .cv_pulse_i(cv_pulse_i),
        .ref_clk_i(ref_clk_i), .alarm_no(alarm_no)
    );

    always #4 clk_i = ~clk_i;

    // requirement-level model state
    logic m1, m2, m3, m_alarm;
    int   m_err, m_edges, m_idle;
    bit   ref_on;
    int   ref_ph;

    function automatic int sat_add(int v, bit p);
        return (p && v < TH) ? v + 1 : v;
    endfunction

    task automatic check(string tag);
        n_chk++;
        if (alarm_no !== m_alarm) begin
            n_bad++;
            $display("FAIL %s cycle %0d: alarm_no=%b expected %b", tag, cyc, alarm_no, m_alarm);
        end
    endtask

    task automatic model_step(bit cv, bit r);
        bit rise, stl, close;
        rise  = m2 & ~m3;
        stl   = (m_idle == TO);
        close = rise & ~stl & (m_edges == WE - 1);
        if (stl)        m_alarm = 1'b1;
        else if (close) m_alarm = !(m_err >= TH);
        if (stl)        m_err = 0;
        else if (close) m_err = cv ? 1 : 0;
        else            m_err = sat_add(m_err, cv);
        if (stl)        m_edges = 0;
        else if (close) m_edges = 0;
        else if (rise)  m_edges++;
        if (rise)       m_idle = 0;
        else if (!stl)  m_idle++;
        m3 = m2; m2 = m1; m1 = r;
    endtask

    // mode 0 none, 1 random pct, 2 up to target per window, 3 flood
    task automatic run(int n, int mode, int arg, string tag);
        for (int i = 0; i < n; i++) begin
            bit cv;
            @(negedge clk_i);
            cyc++;
            check(tag);
            case (mode)
                1: cv = ($urandom % 100) < arg;
                2: cv = (m_err < arg);
                3: cv = 1'b1;
                default: cv = 1'b0;
            endcase
            if (ref_on) begin
                ref_ph++;
                if (ref_ph >= HALF) begin ref_ph = 0; ref_clk_i = ~ref_clk_i; end
            end
            cv_pulse_i = cv;
            model_step(cv, ref_clk_i);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_ni = 1'b0; cv_pulse_i = 1'b0; ref_clk_i = 1'b0;
        ref_on = 1'b0; ref_ph = 0;
        m1 = 0; m2 = 0; m3 = 0; m_alarm = 1'b1;
        m_err = 0; m_edges = 0; m_idle = 0;
        repeat (3) @(negedge clk_i);
        check("R1 during reset");
        rst_ni = 1'b1;
        run(20, 3, 0, "R1 after reset, no reference edges");
        ref_on = 1'b1;
        // align to a window start: run none until a window closes
        run(50, 0, 0, "R2 first window, no errors");
        run(80, 2, TH - 1, "R4 one below threshold");
        run(80, 2, TH, "R3 exactly at threshold");
        run(80, 3, 0, "R6 flood beyond counter range");
        run(80, 0, 0, "R5 quiet window after alarm");
        run(120, 1, 30, "R7 random pulses across boundaries");
        run(80, 3, 0, "R3 alarm before stall");
        ref_on = 1'b0;
        run(90, 3, 0, "R8 reference stalled");
        ref_on = 1'b1;
        run(120, 3, 0, "R8 recovery and fresh window");
        run(600, 1, 12, "R5 random mix");
        run(400, 1, 3, "R4 sparse random");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule